// File: doc/BRIEF.md
# Master-Clock-to-Frame Ratio Detector

This block runs on the audio master clock and works out how many master-clock cycles make up one frame of the left/right (frame) clock. The frame clock arrives asynchronously, passes through a two-stage synchronizer, and each period is measured from one rising edge to the next. The measured count is compared against a fixed set of oversampling ratios. It reports the ratio code it locked to, whether that code is currently trusted, and whether the latest period matched nothing. It also reports which digital-filter mode the locked ratio calls for.

A second function watches how often the locked ratio changes. When two changes come too close together, measured in frame periods, it raises an instability flag. The system uses that flag to keep the converter in standby until the clocks settle. The flag drops again after a full quiet window.

Top module: `mclk_ratio_detect`

## Requirements
- R1: A frame period is measured from one synchronized rising edge of `lrclk_in` to the next, as the number of `clk_mclk` cycles between them. The first rising edge after reset only starts the count and produces no measurement.
- R2: A count snaps to a code when it lies within 32 cycles (inclusive) of that code's ratio. The codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 and 6=1152. Where two windows overlap, the lower code wins, so 160 gives code 0 and 161 gives code 1.
- R3: A code becomes the reported `ratio_code`, with `ratio_valid` high, only after two consecutive measurements snap to it. A single outlying period leaves the reported code and `ratio_valid` unchanged.
- R4: A measurement that matches no ratio sets `ratio_unsupported`, clears `ratio_valid` and keeps the last reported code. The next matching measurement clears `ratio_unsupported`, but `ratio_valid` returns only after confirmation as in R3.
- R5: The period counter saturates at 2047. If no rising edge arrives for 2047 cycles after a primed edge, an unsupported measurement is reported and the counter never wraps.
- R6: `filter_low_os` is 1 while the reported code is 0 or 1, and 0 for codes 2 to 6.
- R7: A confirmed change of the reported code sets `rate_unstable` if it comes within WINDOW frame periods of the previous confirmed change. The first acquisition after reset is not a change.
- R8: Every rising frame-clock edge counts one frame. `rate_unstable` clears once WINDOW frames have passed since the last change with no further change.
- R9: A change that lands on the very frame at which the window would expire still counts as inside the window and sets `rate_unstable`. A change one frame later does not.
- R10: During and after reset, `ratio_code`=2, and `ratio_valid`, `ratio_unsupported`, `filter_low_os` and `rate_unstable` are all 0.
- R11: Periods that alternate within the tolerance window around one ratio keep that code reported with `ratio_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock; all state runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lrclk_in | input | 1 | Asynchronous frame clock to be measured |
| ratio_code | output | 3 | Reported ratio code (0=128 up to 6=1152) |
| ratio_valid | output | 1 | Reported code is confirmed and current |
| ratio_unsupported | output | 1 | Last measurement matched no ratio |
| filter_low_os | output | 1 | Reduced-oversampling filter mode selected |
| rate_unstable | output | 1 | Ratio changed twice within the window |

## Verification
Ratio confirmation and window expiry in the churn monitor can fall in the same master-clock cycle, because both are driven by the same synchronized frame edge. The bench provokes this with a second change on exactly the WINDOW-th frame after the first, and expects `rate_unstable` to rise. It then repeats the pattern one frame later and expects the flag to stay low. The window is shortened through its parameter so that both cases fit in a short run.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;

    localparam int NUM_RATIOS = 7;
    localparam int CODE_W     = 3;
    localparam int CNT_W      = 11;

    typedef logic [CODE_W-1:0] ratio_code_t;

    localparam ratio_code_t RESET_CODE  = 3'd2;
    localparam ratio_code_t LOW_OS_LAST = 3'd1;

    function automatic int unsigned ratio_of(input int idx);
        case (idx)
            0:       return 128;
            1:       return 192;
            2:       return 256;
            3:       return 384;
            4:       return 512;
            5:       return 768;
            default: return 1152;
        endcase
    endfunction

endpackage

// File: rtl/lrclk_sync.sv
module lrclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_in};
        s_d.last  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.last;

    // R1: a rising edge is a single-cycle event
    a_r1_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/period_counter.sv
module period_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic             meas_stb_o,
    output logic [CNT_W-1:0] meas_cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             primed;
    } pc_state_t;

    pc_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        meas_stb_o = 1'b0;
        meas_cnt_o = s_q.cnt;
        if (rise_i) begin
            meas_stb_o = s_q.primed;
            s_d.cnt    = CNT_ONE;
            s_d.primed = 1'b1;
        end else if (s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + CNT_ONE;
            if (s_q.primed && (s_q.cnt == CNT_MAX - CNT_ONE)) begin
                meas_stb_o = 1'b1;
                meas_cnt_o = CNT_MAX;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R5: a saturated counter stays saturated until an edge arrives
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && !rise_i) |=> (s_q.cnt == CNT_MAX));

    // R1: the counter restarts after every rising edge
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> (s_q.cnt == CNT_ONE && s_q.primed));

endmodule

// File: rtl/ratio_matcher.sv
module ratio_matcher
    import ratio_det_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 32
) (
    input  logic [CNT_W-1:0] count_i,
    output logic             hit_o,
    output ratio_code_t      code_o
);

    logic [NUM_RATIOS-1:0] hit_vec;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
        localparam int               RV = int'(ratio_of(g));
        localparam logic [CNT_W-1:0] LO = CNT_W'(RV - TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'(RV + TOL);
        assign hit_vec[g] = (count_i >= LO) && (count_i <= HI);
    end

    always_comb begin
        code_o = RESET_CODE;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                code_o = ratio_code_t'(i);
            end
        end
    end

    assign hit_o = |hit_vec;

endmodule

// File: rtl/churn_monitor.sv
module churn_monitor #(
    parameter int WINDOW = 1026
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_i,
    input  logic change_i,
    output logic unstable_o
);

    localparam int            CW       = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WINDOW - 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
        logic          unstable;
    } churn_state_t;

    churn_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (change_i) begin
            if (s_q.armed) begin
                s_d.unstable = 1'b1;
            end
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else if (frame_i && s_q.armed) begin
            if (s_q.cnt == LAST_CNT) begin
                s_d.armed    = 1'b0;
                s_d.unstable = 1'b0;
                s_d.cnt      = '0;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign unstable_o = s_q.unstable;

    // R7: instability is only ever raised by a change
    a_r7_set_by_change: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.unstable) |-> $past(change_i));

    // R8: the flag drops only on a quiet frame
    a_r8_clear_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.unstable) |-> ($past(frame_i) && !$past(change_i)));

    // R8: the frame counter stays inside the window
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST_CNT);

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import ratio_det_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TOLERANCE   = 32,
    parameter int WINDOW      = 1026
) (
    input  logic              clk_mclk,
    input  logic              rst_n,
    input  logic              lrclk_in,
    output logic [CODE_W-1:0] ratio_code,
    output logic              ratio_valid,
    output logic              ratio_unsupported,
    output logic              filter_low_os,
    output logic              rate_unstable
);

    typedef struct packed {
        ratio_code_t code;
        logic        valid;
        logic        unsup;
        logic        acquired;
        logic        prev_hit;
        ratio_code_t prev_code;
    } det_state_t;

    logic             rise;
    logic             meas_stb;
    logic [CNT_W-1:0] meas_cnt;
    logic             snap_hit;
    ratio_code_t      snap_code;
    logic             change;

    det_state_t s_d, s_q;

    lrclk_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk_mclk),
        .rst_n    (rst_n),
        .async_in (lrclk_in),
        .rise_o   (rise)
    );

    period_counter #(.CNT_W(CNT_W)) count_i (
        .clk        (clk_mclk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .meas_stb_o (meas_stb),
        .meas_cnt_o (meas_cnt)
    );

    ratio_matcher #(.CNT_W(CNT_W), .TOL(TOLERANCE)) match_i (
        .count_i (meas_cnt),
        .hit_o   (snap_hit),
        .code_o  (snap_code)
    );

    always_comb begin
        s_d    = s_q;
        change = 1'b0;
        if (meas_stb) begin
            if (snap_hit) begin
                s_d.unsup = 1'b0;
                if (s_q.prev_hit && (s_q.prev_code == snap_code)) begin
                    change       = s_q.acquired && (snap_code != s_q.code);
                    s_d.code     = snap_code;
                    s_d.valid    = 1'b1;
                    s_d.acquired = 1'b1;
                end
                s_d.prev_hit  = 1'b1;
                s_d.prev_code = snap_code;
            end else begin
                s_d.unsup    = 1'b1;
                s_d.valid    = 1'b0;
                s_d.prev_hit = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_mclk) begin
        if (!rst_n) begin
            s_q <= '{code: RESET_CODE, prev_code: RESET_CODE, default: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    churn_monitor #(.WINDOW(WINDOW)) churn_i (
        .clk        (clk_mclk),
        .rst_n      (rst_n),
        .frame_i    (rise),
        .change_i   (change),
        .unstable_o (rate_unstable)
    );

    assign ratio_code        = s_q.code;
    assign ratio_valid       = s_q.valid;
    assign ratio_unsupported = s_q.unsup;
    assign filter_low_os     = (s_q.code <= LOW_OS_LAST);

    // R4: a trusted code and an unsupported period never coexist
    a_r4_exclusive: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        ratio_valid |-> !ratio_unsupported);

    // R3: the reported code only moves on a measurement
    a_r3_code_on_meas: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        !$stable(s_q.code) |-> $past(meas_stb));

    // R3: trust is granted only on a matching measurement
    a_r3_valid_on_hit: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        $rose(ratio_valid) |-> ($past(meas_stb) && $past(snap_hit)));

endmodule

// File: tb/mclk_ratio_detect_tb_top.sv
`timescale 1ns/1ps
module mclk_ratio_detect_tb_top;

    localparam int WIN = 8;
    localparam int NV  = 10;

    localparam int TBL_PERIOD [NV] = '{256, 128, 192, 384, 512, 768, 1152, 160, 161, 1000};
    localparam int TBL_CODE   [NV] = '{2,   0,   1,   3,   4,   5,   6,    0,   1,   1};
    localparam int TBL_VALID  [NV] = '{1,   1,   1,   1,   1,   1,   1,    1,   1,   0};
    localparam int TBL_UNSUP  [NV] = '{0,   0,   0,   0,   0,   0,   0,    0,   0,   1};
    localparam int TBL_LOW    [NV] = '{0,   1,   1,   0,   0,   0,   0,    1,   1,   1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrclk = 1'b0;
    logic [2:0] code;
    logic       valid, unsup, low_os, unstable;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mclk_ratio_detect #(.WINDOW(WIN)) dut_i (
        .clk_mclk          (clk),
        .rst_n             (rst_n),
        .lrclk_in          (lrclk),
        .ratio_code        (code),
        .ratio_valid       (valid),
        .ratio_unsupported (unsup),
        .filter_low_os     (low_os),
        .rate_unstable     (unstable)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_frames(input int period, input int n);
        for (int f = 0; f < n; f++) begin
            lrclk = 1'b1;
            repeat (period / 2) @(negedge clk);
            lrclk = 1'b0;
            repeat (period - period / 2) @(negedge clk);
        end
    endtask

    task automatic check_all(input string tag, input int c, input int v, input int u);
        check("R2", {tag, " code"}, int'(code), c);
        check("R3", {tag, " valid"}, int'(valid), v);
        check("R4", {tag, " unsupported"}, int'(unsup), u);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset values
        check("R10", "reset code", int'(code), 2);
        check("R10", "reset valid", int'(valid), 0);
        check("R10", "reset unsupported", int'(unsup), 0);
        check("R10", "reset filter", int'(low_os), 0);
        check("R10", "reset unstable", int'(unstable), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: after one edge there is no measurement yet
        run_frames(256, 1);
        check("R1", "no measurement after first edge", int'(valid), 0);

        // table walk: R1 R2 R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            run_frames(TBL_PERIOD[i], 10);
            check_all($sformatf("R1 period %0d", TBL_PERIOD[i]), TBL_CODE[i], TBL_VALID[i], TBL_UNSUP[i]);
            check("R6", $sformatf("filter period %0d", TBL_PERIOD[i]), int'(low_os), TBL_LOW[i]);
            check("R7", $sformatf("unstable period %0d", TBL_PERIOD[i]), int'(unstable), 0);
        end

        // R3: a single outlier is ignored
        run_frames(256, 10);
        check_all("R3 settle", 2, 1, 0);
        run_frames(384, 1);
        run_frames(256, 1);
        check_all("R3 outlier held", 2, 1, 0);
        run_frames(256, 2);
        check_all("R3 after outlier", 2, 1, 0);

        // R11: jitter inside tolerance
        for (int k = 0; k < 10; k++) begin
            run_frames(250, 1);
            run_frames(262, 1);
        end
        check_all("R11 jitter", 2, 1, 0);
        check("R11", "jitter unstable", int'(unstable), 0);

        // R7 / R8: two changes close together
        run_frames(384, 3);
        run_frames(256, 3);
        check("R7", "two close changes", int'(unstable), 1);
        check_all("R7 code", 2, 1, 0);
        run_frames(256, 4);
        check("R8", "inside window still set", int'(unstable), 1);
        run_frames(256, 8);
        check("R8", "cleared after window", int'(unstable), 0);

        // R9: change on the expiry frame
        run_frames(384, 8);
        run_frames(256, 3);
        check("R9", "change on expiry frame", int'(unstable), 1);
        run_frames(256, 12);
        check("R8", "clear before control", int'(unstable), 0);
        run_frames(384, 9);
        run_frames(256, 3);
        check("R9", "change one frame after expiry", int'(unstable), 0);
        check_all("R9 code", 2, 1, 0);

        // R5: stalled frame clock
        lrclk = 1'b0;
        repeat (2100) @(negedge clk);
        check_all("R5 stall", 2, 0, 1);
        run_frames(256, 2);
        check_all("R4 first match", 2, 0, 0);
        run_frames(256, 2);
        check_all("R4 reconfirmed", 2, 1, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule